// File: doc/BRIEF.md
# Triggered Multi-Channel ADC Scan Controller

This block sequences an external analog-to-digital converter across a set of input channels. A scan is launched either by a one-cycle software start pulse or by a rising edge on one of several hardware trigger lines. The hardware lines are synchronised to the clock, and one of them is chosen by a select field and gated by an enable bit. Each start converts every enabled channel once, lowest channel number first. Each conversion uses a start/done handshake with the converter. The controller then returns to idle.

Each raw conversion is cut to the chosen resolution (10, 12 or 16 bits) and extended to a 16-bit word. Unsigned results are zero-extended. Signed (two's complement) results have their sign bit copied upwards. Whether a channel's result is signed depends on a two-bit coding mode and on whether that channel is wired single-ended or differential. The word leaves with its 4-bit channel number on a valid/ready port. The next conversion waits until the current word has been accepted. With the power-saving option set, the converter enable is low between scans. When it is raised at the start of a scan, a fixed warm-up wait is inserted before the first conversion.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset, `busy`, `res_valid`, `conv_start` and `overrun` are 0, every channel is disabled, and `conv_en` is 1 while `sleep_en` is 0.
- R2: A one-cycle `sw_start` while idle with at least one channel enabled begins a scan, and `conv_start` is visible in the cycle after the pulse.
- R3: With `trig_en`=1, a rising edge on `hw_trig[trig_sel]` begins a scan, and `conv_start` appears three cycles after the edge. Edges on lines other than the selected one, and all edges while `trig_en`=0, have no effect.
- R4: A channel's enable bit is set by its bit in `ch_en_set` and cleared by its bit in `ch_en_clr`. When both bits are high in the same cycle, the clear takes effect.
- R5: A scan converts exactly the channels enabled when it starts, in ascending order, with `conv_ch` giving the channel. Each produces one result tagged with that channel on `res_ch`. After the last result is accepted, `busy` is 0.
- R6: `conv_start` is a one-cycle pulse. The controller then waits for `conv_done`, captures `conv_data` on that cycle, and presents the result with `res_valid` in the next cycle.
- R7: While `res_valid`=1 and `res_ready`=0, `res_data` and `res_ch` hold steady and no new `conv_start` is issued.
- R8: `sign_mode` selects signedness: 0 = single-ended unsigned, differential signed; 1 = single-ended signed, differential unsigned; 2 = all unsigned; 3 = all signed. A channel is differential when its `ch_diff` bit is 1.
- R9: `res_sel` selects resolution: 0 = 10 bits, 1 = 12 bits, 2 or 3 = 16 bits. Only the low bits of `conv_data` are used. An unsigned result is zero-extended and a signed result is sign-extended to 16 bits (12-bit 0xF43 gives 0xFF43; 0x467 gives 0x0467).
- R10: With `sleep_en`=1, `conv_en` is 0 whenever the controller is idle. It is 1 from the start of a scan, and the first `conv_start` comes STARTUP_CYC cycles later than it would without sleep.
- R11: A software start or a selected hardware edge that arrives while a scan is running, including the cycle in which the last result is accepted, is ignored. It sets `overrun`, which stays 1 until reset.
- R12: A start while no channel is enabled is ignored: `busy` stays 0 and no conversion is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_start | input | 1 | Software start pulse |
| hw_trig | input | NUM_TRIG | Asynchronous hardware trigger lines |
| trig_sel | input | clog2(NUM_TRIG) | Index of the hardware trigger line in use |
| trig_en | input | 1 | Enables hardware triggering |
| ch_en_set | input | NUM_CH | Per-channel enable strobes |
| ch_en_clr | input | NUM_CH | Per-channel disable strobes |
| ch_diff | input | NUM_CH | Channel is differential when 1 |
| sign_mode | input | 2 | Signedness coding mode |
| res_sel | input | 2 | Resolution select |
| sleep_en | input | 1 | Power converter only during scans |
| conv_en | output | 1 | Converter power enable |
| conv_start | output | 1 | Start-of-conversion pulse |
| conv_ch | output | 4 | Channel for the conversion |
| conv_done | input | 1 | Conversion complete |
| conv_data | input | 16 | Raw conversion value |
| res_valid | output | 1 | Formatted result available |
| res_ready | input | 1 | Consumer accepts result |
| res_data | output | 16 | Formatted result |
| res_ch | output | 4 | Channel of the result |
| busy | output | 1 | Scan in progress |
| overrun | output | 1 | Sticky: start arrived during a scan |

## Verification
The sharpest overlap is a new start arriving in the same cycle that the consumer accepts the final result of a scan. At that moment the controller is still busy, so the start must be dropped and flagged as an overrun rather than launching a new scan. The bench pulses `sw_start` together with the last `res_ready`. It then expects `overrun` set, `busy` low and no `conv_start` over the following cycles. A second case places a start in the cycle that `conv_done` arrives mid-scan, and requires the running scan to complete with exactly its original channel list.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int RES_W = 16;
  localparam int LO_W  = 10;
  localparam int MID_W = 12;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WARM,
    ST_SEL,
    ST_WAIT,
    ST_PUSH
  } seq_state_e;

  typedef enum logic [1:0] {
    SM_SE_U_DF_S = 2'd0,
    SM_SE_S_DF_U = 2'd1,
    SM_ALL_U     = 2'd2,
    SM_ALL_S     = 2'd3
  } sign_mode_e;

  typedef enum logic [1:0] {
    RS_10  = 2'd0,
    RS_12  = 2'd1,
    RS_16A = 2'd2,
    RS_16B = 2'd3
  } res_sel_e;
endpackage

// File: rtl/adc_rst_sync.sv
module adc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic q1, q2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q1 <= 1'b0;
      q2 <= 1'b0;
    end else begin
      q1 <= 1'b1;
      q2 <= q1;
    end
  end

  assign rst_sync_n = q2;
endmodule

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
  parameter int NUM_TRIG = 4,
  localparam int TSEL_W = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TRIG-1:0] trig_in,
  input  logic [TSEL_W-1:0]   trig_sel,
  input  logic                trig_en,
  output logic                trig_edge
);
  logic [NUM_TRIG-1:0] s1_q, s2_q;
  logic                sel_line;
  logic                prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= trig_in;
      s2_q <= s1_q;
    end
  end

  always_comb sel_line = s2_q[trig_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sel_line;
  end

  assign trig_edge = trig_en & sel_line & ~prev_q;
endmodule

// File: rtl/adc_ch_mask.sv
module adc_ch_mask #(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] set_i,
  input  logic [NUM_CH-1:0] clr_i,
  output logic [NUM_CH-1:0] en_o
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_bit
    logic bit_q;
    logic bit_d;
    logic bit_ce;

    always_comb begin
      bit_ce = set_i[i] | clr_i[i];
      bit_d  = clr_i[i] ? 1'b0 : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bit_q <= 1'b0;
      else if (bit_ce) bit_q <= bit_d;
    end

    assign en_o[i] = bit_q;
  end
endmodule

// File: rtl/adc_low_pick.sv
module adc_low_pick #(
  parameter int N = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     vec,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/adc_result_fmt.sv
module adc_result_fmt
  import adc_seq_pkg::*;
(
  input  logic [RES_W-1:0] raw,
  input  logic [1:0]       res_sel,
  input  logic             diff,
  input  logic [1:0]       sign_mode,
  output logic [RES_W-1:0] fmt
);
  localparam logic [RES_W-1:0] KEEP_LO  = {RES_W{1'b1}} >> (RES_W - LO_W);
  localparam logic [RES_W-1:0] KEEP_MID = {RES_W{1'b1}} >> (RES_W - MID_W);
  localparam logic [RES_W-1:0] KEEP_ALL = {RES_W{1'b1}};

  logic [RES_W-1:0] keep;
  logic             sbit;
  logic             is_signed;

  always_comb begin
    case (res_sel_e'(res_sel))
      RS_10:   begin keep = KEEP_LO;  sbit = raw[LO_W-1];  end
      RS_12:   begin keep = KEEP_MID; sbit = raw[MID_W-1]; end
      default: begin keep = KEEP_ALL; sbit = raw[RES_W-1]; end
    endcase
  end

  always_comb begin
    case (sign_mode_e'(sign_mode))
      SM_SE_U_DF_S: is_signed = diff;
      SM_SE_S_DF_U: is_signed = ~diff;
      SM_ALL_U:     is_signed = 1'b0;
      default:      is_signed = 1'b1;
    endcase
  end

  always_comb begin
    fmt = raw & keep;
    if (is_signed && sbit) fmt = fmt | ~keep;
  end
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH      = 16,
  parameter int NUM_TRIG    = 4,
  parameter int STARTUP_CYC = 6,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int TSEL_W = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sw_start,
  input  logic [NUM_TRIG-1:0] hw_trig,
  input  logic [TSEL_W-1:0]   trig_sel,
  input  logic                trig_en,
  input  logic [NUM_CH-1:0]   ch_en_set,
  input  logic [NUM_CH-1:0]   ch_en_clr,
  input  logic [NUM_CH-1:0]   ch_diff,
  input  logic [1:0]          sign_mode,
  input  logic [1:0]          res_sel,
  input  logic                sleep_en,
  output logic                conv_en,
  output logic                conv_start,
  output logic [CH_W-1:0]     conv_ch,
  input  logic                conv_done,
  input  logic [RES_W-1:0]    conv_data,
  output logic                res_valid,
  input  logic                res_ready,
  output logic [RES_W-1:0]    res_data,
  output logic [CH_W-1:0]     res_ch,
  output logic                busy,
  output logic                overrun
);
  localparam int WARM_W = $clog2(STARTUP_CYC + 1);

  logic              rst_i_n;
  logic              hw_edge;
  logic              start_req;
  logic [NUM_CH-1:0] ch_en;
  logic [CH_W-1:0]   pick_ch;
  logic [RES_W-1:0]  fmt_val;

  seq_state_e        state_q, state_d;
  logic [NUM_CH-1:0] pend_q, pend_d;
  logic [CH_W-1:0]   cur_q;
  logic [WARM_W-1:0] warm_q, warm_d;
  logic [RES_W-1:0]  data_q;
  logic              ovr_q, ovr_d;
  logic              ld_cur, cap_res;

  adc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  adc_trig_sync #(.NUM_TRIG(NUM_TRIG)) u_trig (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .trig_in   (hw_trig),
    .trig_sel  (trig_sel),
    .trig_en   (trig_en),
    .trig_edge (hw_edge)
  );

  adc_ch_mask #(.NUM_CH(NUM_CH)) u_mask (
    .clk   (clk),
    .rst_n (rst_i_n),
    .set_i (ch_en_set),
    .clr_i (ch_en_clr),
    .en_o  (ch_en)
  );

  adc_low_pick #(.N(NUM_CH)) u_pick (
    .vec (pend_q),
    .idx (pick_ch)
  );

  adc_result_fmt u_fmt (
    .raw       (conv_data),
    .res_sel   (res_sel),
    .diff      (ch_diff[cur_q]),
    .sign_mode (sign_mode),
    .fmt       (fmt_val)
  );

  assign start_req = sw_start | hw_edge;

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    warm_d  = warm_q;
    ovr_d   = ovr_q;
    ld_cur  = 1'b0;
    cap_res = 1'b0;

    if (start_req && state_q != ST_IDLE) ovr_d = 1'b1;

    case (state_q)
      ST_IDLE: begin
        if (start_req && |ch_en) begin
          pend_d = ch_en;
          if (sleep_en) begin
            state_d = ST_WARM;
            warm_d  = WARM_W'(STARTUP_CYC - 1);
          end else begin
            state_d = ST_SEL;
          end
        end
      end
      ST_WARM: begin
        if (warm_q == '0) state_d = ST_SEL;
        else              warm_d  = warm_q - 1'b1;
      end
      ST_SEL: begin
        ld_cur  = 1'b1;
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (conv_done) begin
          cap_res       = 1'b1;
          pend_d[cur_q] = 1'b0;
          state_d       = ST_PUSH;
        end
      end
      ST_PUSH: begin
        if (res_ready) state_d = (|pend_q) ? ST_SEL : ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      warm_q  <= '0;
      ovr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      warm_q  <= warm_d;
      ovr_q   <= ovr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)    cur_q <= '0;
    else if (ld_cur) cur_q <= pick_ch;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)     data_q <= '0;
    else if (cap_res) data_q <= fmt_val;
  end

  assign conv_en    = ~sleep_en | (state_q != ST_IDLE);
  assign conv_start = (state_q == ST_SEL);
  assign conv_ch    = (state_q == ST_SEL) ? pick_ch : cur_q;
  assign res_valid  = (state_q == ST_PUSH);
  assign res_data   = data_q;
  assign res_ch     = cur_q;
  assign busy       = (state_q != ST_IDLE);
  assign overrun    = ovr_q;
endmodule

// File: rtl/adc_scan_ctrl_chk.sv
module adc_scan_ctrl_chk
  import adc_seq_pkg::*;
#(
  parameter int CH_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sleep_en,
  input logic [1:0]       res_sel,
  input logic             conv_en,
  input logic             conv_start,
  input logic             busy,
  input logic             res_valid,
  input logic             res_ready,
  input logic [RES_W-1:0] res_data,
  input logic [CH_W-1:0]  res_ch,
  input logic             overrun
);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data) && $stable(res_ch));

  p_no_conv_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !conv_start);

  p_start_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy);

  p_sleep_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_en && !busy |-> !conv_en);

  p_powered_conv_r10: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> conv_en);

  p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  p_ext10_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_sel == 2'd0 |->
      ($countones(res_data[RES_W-1:LO_W]) == 0 ||
       $countones(res_data[RES_W-1:LO_W]) == RES_W - LO_W));
endmodule

bind adc_scan_ctrl adc_scan_ctrl_chk #(.CH_W(CH_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sleep_en   (sleep_en),
  .res_sel    (res_sel),
  .conv_en    (conv_en),
  .conv_start (conv_start),
  .busy       (busy),
  .res_valid  (res_valid),
  .res_ready  (res_ready),
  .res_data   (res_data),
  .res_ch     (res_ch),
  .overrun    (overrun)
);

// File: tb/sim_adc_scan_ctrl.sv
`timescale 1ns/1ps
module sim_adc_scan_ctrl;
  localparam int NUM_CH = 16;
  localparam int NUM_TRIG = 4;
  localparam int STARTUP = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic sw_start;
  logic [NUM_TRIG-1:0] hw_trig;
  logic [1:0] trig_sel;
  logic trig_en;
  logic [NUM_CH-1:0] ch_en_set, ch_en_clr, ch_diff;
  logic [1:0] sign_mode, res_sel;
  logic sleep_en;
  logic conv_en, conv_start, conv_done;
  logic [3:0] conv_ch, res_ch;
  logic [15:0] conv_data, res_data;
  logic res_valid, res_ready, busy, overrun;

  int nchk = 0;
  int nfail = 0;
  logic [15:0] last_res;

  always #4 clk = ~clk;

  adc_scan_ctrl #(.NUM_CH(NUM_CH), .NUM_TRIG(NUM_TRIG), .STARTUP_CYC(STARTUP)) u0 (
    .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .hw_trig(hw_trig),
    .trig_sel(trig_sel), .trig_en(trig_en), .ch_en_set(ch_en_set),
    .ch_en_clr(ch_en_clr), .ch_diff(ch_diff), .sign_mode(sign_mode),
    .res_sel(res_sel), .sleep_en(sleep_en), .conv_en(conv_en),
    .conv_start(conv_start), .conv_ch(conv_ch), .conv_done(conv_done),
    .conv_data(conv_data), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .res_ch(res_ch), .busy(busy), .overrun(overrun)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_fmt(input logic [15:0] raw, input logic [1:0] rs,
                                          input logic df, input logic [1:0] md);
    int w;
    bit sg;
    logic [15:0] v;
    w = (rs == 2'd0) ? 10 : (rs == 2'd1) ? 12 : 16;
    case (md)
      2'd0: sg = df;
      2'd1: sg = !df;
      2'd2: sg = 1'b0;
      default: sg = 1'b1;
    endcase
    v = '0;
    for (int i = 0; i < 16; i++) begin
      if (i < w) v[i] = raw[i];
      else if (sg) v[i] = raw[w-1];
    end
    return v;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    sw_start = 0; hw_trig = '0; trig_sel = '0; trig_en = 0;
    ch_en_set = '0; ch_en_clr = '0; ch_diff = '0; sign_mode = '0; res_sel = '0;
    sleep_en = 0; conv_done = 0; conv_data = '0; res_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [NUM_CH-1:0] m, input logic [NUM_CH-1:0] df,
                         input logic [1:0] md, input logic [1:0] rs, input logic slp);
    @(negedge clk);
    ch_en_set = m; ch_en_clr = ~m; ch_diff = df; sign_mode = md; res_sel = rs; sleep_en = slp;
    @(negedge clk);
    ch_en_set = '0; ch_en_clr = '0;
  endtask

  task automatic watch_idle(input string req);
    int bad = 0;
    repeat (8) begin
      @(negedge clk);
      if (busy || conv_start) bad++;
    end
    chk(bad == 0, req, bad, 0);
  endtask

  // kind < 0: software start; otherwise hardware line index
  // ovr 1: extra start with first conv_done; ovr 2: extra start with last accept
  task automatic serve(input int kind, input logic [NUM_CH-1:0] emask, input int ovr,
                       input bit fixed, input logic [15:0] fixed_raw);
    int first_lat;
    int left;
    bit first;
    first_lat = ((kind < 0) ? 1 : 3) + (sleep_en ? STARTUP : 0);
    left = $countones(emask);
    first = 1;
    if (kind < 0) sw_start = 1'b1;
    else hw_trig[kind] = 1'b1;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (emask[ch]) begin
        int n;
        int d;
        bit seen;
        logic [15:0] raw;
        logic [15:0] expv;
        n = 0;
        seen = 0;
        while (!seen && n < 60) begin
          @(negedge clk);
          n++;
          if (n == 1) begin sw_start = 0; res_ready = 0; end
          if (n == 2) hw_trig = '0;
          if (conv_start) seen = 1;
        end
        chk(seen, "R6 conversion issued", seen, 1);
        if (first) chk(n == first_lat, "R2 R3 R10 start latency", n, first_lat);
        chk(conv_ch == ch[3:0], "R5 channel order", conv_ch, ch);
        chk(conv_en, "R10 converter powered", conv_en, 1);
        raw = fixed ? fixed_raw : 16'($urandom);
        d = $urandom % 3;
        repeat (1 + d) @(negedge clk);
        conv_done = 1'b1;
        conv_data = raw;
        if (ovr == 1 && first) sw_start = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        conv_data = 16'($urandom);
        sw_start = 1'b0;
        expv = exp_fmt(raw, res_sel, ch_diff[ch], sign_mode);
        chk(res_valid, "R6 result valid", res_valid, 1);
        chk(res_data == expv, "R8 R9 result value", res_data, expv);
        chk(res_ch == ch[3:0], "R5 result channel", res_ch, ch);
        last_res = res_data;
        d = $urandom % 3;
        repeat (d) begin
          @(negedge clk);
          chk(res_valid && res_data == expv && !conv_start, "R7 hold while stalled", res_data, expv);
        end
        res_ready = 1'b1;
        left--;
        if (ovr == 2 && left == 0) sw_start = 1'b1;
        first = 0;
      end
    end
    @(negedge clk);
    res_ready = 1'b0;
    sw_start = 1'b0;
    chk(!busy && !res_valid, "R5 idle after scan", {busy, res_valid}, 0);
    chk(conv_en == !sleep_en, "R10 enable when idle", conv_en, !sleep_en);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset();
    // R1 reset state
    chk(!busy && !res_valid && !conv_start && !overrun, "R1 reset outputs",
        {busy, res_valid, conv_start, overrun}, 0);
    chk(conv_en, "R1 conv_en without sleep", conv_en, 1);

    // R12 and R1: nothing enabled after reset
    @(negedge clk); sw_start = 1; @(negedge clk); sw_start = 0;
    watch_idle("R12 start with no channels");
    chk(!overrun, "R12 no overrun", overrun, 0);

    // R2 basic software scan
    set_cfg(16'h8421, 16'h0401, 2'd0, 2'd1, 1'b0);
    serve(-1, 16'h8421, 0, 0, '0);

    // R9 sign-extension examples, 12-bit signed (differential in mode 0)
    set_cfg(16'h0020, 16'h0020, 2'd0, 2'd1, 1'b0);
    serve(-1, 16'h0020, 0, 1, 16'hAF43);
    chk(last_res == 16'hFF43, "R9 negative 12-bit", last_res, 16'hFF43);
    serve(-1, 16'h0020, 0, 1, 16'h5467);
    chk(last_res == 16'h0467, "R9 positive 12-bit", last_res, 16'h0467);
    // R8 mode 1: differential unsigned
    set_cfg(16'h0020, 16'h0020, 2'd1, 2'd1, 1'b0);
    serve(-1, 16'h0020, 0, 1, 16'hAF43);
    chk(last_res == 16'h0F43, "R8 mode1 differential unsigned", last_res, 16'h0F43);

    // R4 clear wins over set in the same cycle
    @(negedge clk); ch_en_set = 16'hFFFF; ch_en_clr = 16'h0008;
    @(negedge clk); ch_en_set = '0; ch_en_clr = '0;
    serve(-1, 16'hFFF7, 0, 0, '0);
    @(negedge clk); ch_en_clr = 16'h0001;
    @(negedge clk); ch_en_clr = '0;
    serve(-1, 16'hFFF6, 0, 0, '0);

    // R3 hardware trigger on selected line
    set_cfg(16'h0305, 16'h0300, 2'd3, 2'd0, 1'b0);
    trig_sel = 2'd2; trig_en = 1'b1;
    @(negedge clk);
    serve(2, 16'h0305, 0, 0, '0);
    // R3 disabled trigger ignored
    trig_en = 1'b0; trig_sel = 2'd1;
    @(negedge clk); hw_trig[1] = 1'b1;
    repeat (2) @(negedge clk); hw_trig = '0;
    watch_idle("R3 trigger disabled ignored");
    // R3 unselected line ignored
    trig_en = 1'b1;
    @(negedge clk); hw_trig[3] = 1'b1;
    repeat (2) @(negedge clk); hw_trig = '0;
    watch_idle("R3 unselected line ignored");

    // R10 sleep mode
    set_cfg(16'h0C00, 16'h0400, 2'd2, 2'd2, 1'b1);
    @(negedge clk);
    chk(!conv_en, "R10 idle converter off", conv_en, 0);
    serve(-1, 16'h0C00, 0, 0, '0);
    serve(1, 16'h0C00, 0, 0, '0);

    // constrained random scans
    for (int k = 0; k < 40; k++) begin
      logic [NUM_CH-1:0] m;
      int kind;
      m = NUM_CH'($urandom & $urandom);
      if (m == '0) m = NUM_CH'(1) << ($urandom % NUM_CH);
      set_cfg(m, NUM_CH'($urandom), 2'($urandom), 2'($urandom), 1'($urandom));
      kind = (($urandom % 2) == 0) ? -1 : int'($urandom % NUM_TRIG);
      if (kind >= 0) begin trig_sel = 2'(kind); trig_en = 1'b1; end
      @(negedge clk);
      serve(kind, m, 0, 0, '0);
    end

    // R11 start during running scan
    do_reset();
    chk(!overrun, "R1 overrun clear after reset", overrun, 0);
    set_cfg(16'h0006, 16'h0000, 2'd2, 2'd0, 1'b0);
    serve(-1, 16'h0006, 1, 0, '0);
    chk(overrun, "R11 overrun mid-scan", overrun, 1);
    watch_idle("R11 mid-scan start ignored");

    // R11 start coincident with final acceptance
    do_reset();
    set_cfg(16'h0090, 16'h0080, 2'd0, 2'd0, 1'b0);
    serve(-1, 16'h0090, 2, 0, '0);
    chk(overrun, "R11 overrun at last accept", overrun, 1);
    watch_idle("R11 coincident start ignored");
    chk(overrun, "R11 overrun sticky", overrun, 1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule